// File: doc/BRIEF.md
# UART 16x Sample-Rate Tick Generator

This block makes the timing base for a UART. It runs from one fixed 24 MHz system clock and produces a strobe at sixteen times the baud rate. Both the transmitter and the receiver use this strobe. No derived clock is created. Every output strobe is a one-cycle enable in the system clock domain.

The rate is set in two stages. The first stage is a prescaler that a two-bit mode input controls. It divides the clock by 13, by 1.625 or by 1. The 1.625 divide uses a fractional accumulator that gives 8 enables in every 13 clocks. The second stage is a 16-bit divisor counter that runs on those enables. Software writes the divisor one byte at a time through a small write port. Because the divisor value is the same in every mode, switching the prescaler alone moves the UART between normal and high-speed rates. With the divide-by-13 prescaler, a divisor of 12 gives 9600 baud and a divisor of 96 gives 1200 baud.

Each divisor write or mode change starts a restart cycle. In that cycle the strobe is held low and both stages return to phase zero. This gives a predictable first strobe after reconfiguration.

Top module: `baud16_gen`

## Requirements
- R1: While `rst_n` is low, `tick16` is low. Reset clears both divisor bytes to 0 and sets the prescaler mode register to 00.
- R2: A cycle with `wr_en` high stores `wr_data` into one byte of the divisor. `wr_sel`=0 selects bits 7:0 and `wr_sel`=1 selects bits 15:8. The other byte keeps its value.
- R3: With mode 00, the prescaler gives one enable every 13 clocks. The strobe period is 13·D clocks, where D is the effective divisor.
- R4: With mode 01, the prescaler gives exactly 8 enables in every 13 clocks after a restart, and never two idle clocks in a row. For D a multiple of 8, the strobe period is 13·D/8 clocks. With D=1 there are 64 strobes in 104 clocks.
- R5: With mode 10 or 11, the prescaler enables every clock and the strobe period is D clocks.
- R6: A divisor write, or a change of `mode`, causes a restart in the following cycle. During that cycle `tick16` is low. The first strobe after it comes D clocks later in modes 1x and 13·D clocks later in mode 00.
- R7: A divisor value of 0 behaves exactly as 1. The internal count never exceeds D−1 outside a restart cycle.
- R8: When the strobe period is greater than one clock, each strobe is exactly one clock wide.
- R9: A strobe occurs only in a clock where the prescaler issues an enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 24 MHz system clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode | input | 2 | Prescaler select: 00 = /13, 01 = /1.625, 1x = /1 |
| wr_en | input | 1 | Divisor byte write strobe |
| wr_sel | input | 1 | Byte select: 0 = low byte, 1 = high byte |
| wr_data | input | 8 | Byte value to store |
| tick16 | output | 1 | One-clock strobe at 16x baud rate |

## Verification
The properties assume that `mode` changes only at clock edges and is then held. Any change counts as a restart, so the fractional window counter in the checker always starts from phase zero. They also assume that writes are single-cycle pulses after reset. The stimulus obeys both rules: it drives every input on the falling edge, holds `mode` steady while periods are measured, and keeps divisors small enough that each measurement finishes well inside the run.

// File: rtl/baud_pkg.sv
package baud_pkg;

  typedef enum logic [1:0] {
    PS_DIV_INT  = 2'b00,
    PS_DIV_FRAC = 2'b01,
    PS_BYPASS_A = 2'b10,
    PS_BYPASS_B = 2'b11
  } ps_mode_e;

  function automatic logic mode_is_bypass(input logic [1:0] m);
    return m[1];
  endfunction

  function automatic logic mode_is_frac(input logic [1:0] m);
    return m == PS_DIV_FRAC;
  endfunction

endpackage

// File: rtl/baud_prescaler.sv
module baud_prescaler #(
  parameter int INT_DIV  = 13,
  parameter int FRAC_NUM = 8,
  parameter int FRAC_DEN = 13
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] mode_q,
  input  logic       restart,
  output logic       pre_en
);
  import baud_pkg::*;

  localparam int IW = (INT_DIV > 1) ? $clog2(INT_DIV) : 1;
  localparam int AW = $clog2(FRAC_DEN + FRAC_NUM + 1);

  logic [IW-1:0] int_cnt;
  logic [AW-1:0] acc;
  logic [AW-1:0] acc_sum;
  logic          int_hit;
  logic          frac_hit;
  logic          raw_en;

  // fractional step: add numerator, wrap at denominator
  function automatic logic [AW-1:0] frac_next(input logic [AW-1:0] s, input logic h);
    return h ? AW'(s - AW'(FRAC_DEN)) : s;
  endfunction

  always_comb begin
    int_hit  = (int_cnt == IW'(INT_DIV - 1));
    acc_sum  = acc + AW'(FRAC_NUM);
    frac_hit = (acc_sum >= AW'(FRAC_DEN));
    if (mode_is_bypass(mode_q))     raw_en = 1'b1;
    else if (mode_is_frac(mode_q))  raw_en = frac_hit;
    else                            raw_en = int_hit;
    pre_en = raw_en & ~restart;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || restart) begin
      int_cnt <= '0;
      acc     <= '0;
    end else begin
      int_cnt <= int_hit ? '0 : IW'(int_cnt + 1'b1);
      acc     <= frac_next(acc_sum, frac_hit);
    end
  end

endmodule

// File: rtl/baud_divreg.sv
module baud_divreg #(
  parameter int DIV_W  = 16,
  parameter int BYTE_W = 8
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  wr_en,
  input  logic [$clog2(DIV_W/BYTE_W)-1:0]       wr_sel,
  input  logic [BYTE_W-1:0]                     wr_data,
  input  logic [1:0]                            mode,
  output logic [1:0]                            mode_q,
  output logic [DIV_W-1:0]                      divisor,
  output logic                                  reload
);
  localparam int NB = DIV_W / BYTE_W;
  localparam int SW = $clog2(NB);

  logic [BYTE_W-1:0] bytes_q [NB];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NB; i++) bytes_q[i] <= '0;
      mode_q <= 2'b00;
      reload <= 1'b0;
    end else begin
      for (int i = 0; i < NB; i++)
        if (wr_en && wr_sel == SW'(i)) bytes_q[i] <= wr_data;
      mode_q <= mode;
      reload <= wr_en | (mode != mode_q);
    end
  end

  for (genvar g = 0; g < NB; g++) begin : g_slice
    assign divisor[g*BYTE_W +: BYTE_W] = bytes_q[g];
  end

endmodule

// File: rtl/baud_divcount.sv
module baud_divcount #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] divisor,
  input  logic             pre_en,
  input  logic             restart,
  output logic [DIV_W-1:0] cnt,
  output logic [DIV_W-1:0] last,
  output logic             tick
);
  // zero divisor behaves as one
  function automatic logic [DIV_W-1:0] terminal(input logic [DIV_W-1:0] d);
    return (d == '0) ? '0 : DIV_W'(d - 1'b1);
  endfunction

  always_comb begin
    last = terminal(divisor);
    tick = pre_en & ~restart & (cnt == last);
  end

  always_ff @(posedge clk) begin
    if (!rst_n || restart)
      cnt <= '0;
    else if (pre_en)
      cnt <= (cnt == last) ? '0 : DIV_W'(cnt + 1'b1);
  end

endmodule

// File: rtl/baud16_gen.sv
module baud16_gen #(
  parameter int DIV_W    = 16,
  parameter int BYTE_W   = 8,
  parameter int INT_DIV  = 13,
  parameter int FRAC_NUM = 8,
  parameter int FRAC_DEN = 13
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic [1:0]                      mode,
  input  logic                            wr_en,
  input  logic [$clog2(DIV_W/BYTE_W)-1:0] wr_sel,
  input  logic [BYTE_W-1:0]               wr_data,
  output logic                            tick16
);
  logic [1:0]       mode_q;
  logic [DIV_W-1:0] divisor;
  logic             reload;
  logic             pre_en;
  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] last;

  baud_divreg #(.DIV_W(DIV_W), .BYTE_W(BYTE_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .mode(mode), .mode_q(mode_q),
    .divisor(divisor), .reload(reload)
  );

  baud_prescaler #(.INT_DIV(INT_DIV), .FRAC_NUM(FRAC_NUM), .FRAC_DEN(FRAC_DEN)) u_pre (
    .clk(clk), .rst_n(rst_n), .mode_q(mode_q), .restart(reload), .pre_en(pre_en)
  );

  baud_divcount #(.DIV_W(DIV_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .divisor(divisor), .pre_en(pre_en),
    .restart(reload), .cnt(cnt), .last(last), .tick(tick16)
  );

endmodule

// File: rtl/baud16_gen_chk.sv
module baud16_gen_chk #(
  parameter int DIV_W    = 16,
  parameter int FRAC_NUM = 8,
  parameter int FRAC_DEN = 13
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [1:0]       mode_q,
  input logic             reload,
  input logic             pre_en,
  input logic [DIV_W-1:0] cnt,
  input logic [DIV_W-1:0] last,
  input logic             tick16
);
  localparam int WW = $clog2(FRAC_DEN + 1);

  logic          frac_active;
  logic [WW-1:0] win_cyc;
  logic [WW-1:0] win_en;

  assign frac_active = (mode_q == 2'b01) && !reload;

  always_ff @(posedge clk) begin
    if (!rst_n || !frac_active || win_cyc == WW'(FRAC_DEN - 1)) begin
      win_cyc <= '0;
      win_en  <= '0;
    end else begin
      win_cyc <= WW'(win_cyc + 1'b1);
      win_en  <= WW'(win_en + WW'(pre_en));
    end
  end

  p_frac_window_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (frac_active && win_cyc == WW'(FRAC_DEN - 1)) |-> (WW'(win_en + WW'(pre_en)) == WW'(FRAC_NUM)));

  p_frac_no_double_gap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (frac_active && !pre_en) |=> (pre_en || reload));

  p_bypass_every_clock_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q[1] && !reload) |-> pre_en);

  p_write_restarts_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> reload);

  p_restart_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    reload |-> !tick16);

  p_count_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !reload |-> (cnt <= last));

  p_one_wide_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (tick16 && last != '0 && !mode_q[1]) |=> !tick16);

  p_one_wide_bypass_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (tick16 && last != '0) |=> !tick16);

  p_tick_on_enable_r9: assert property (@(posedge clk) disable iff (!rst_n)
    tick16 |-> pre_en);

endmodule

bind baud16_gen baud16_gen_chk #(.DIV_W(DIV_W), .FRAC_NUM(FRAC_NUM), .FRAC_DEN(FRAC_DEN)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .mode_q(mode_q), .reload(reload),
  .pre_en(pre_en), .cnt(cnt), .last(last), .tick16(tick16)
);

// File: tb/test_baud16_gen.sv
`timescale 1ns/1ps
module test_baud16_gen;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] mode = 2'b00;
  logic       wr_en = 1'b0;
  logic [0:0] wr_sel = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       tick16;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  baud16_gen i_baud16_gen (
    .clk(clk), .rst_n(rst_n), .mode(mode), .wr_en(wr_en),
    .wr_sel(wr_sel), .wr_data(wr_data), .tick16(tick16)
  );

  // {mode, divisor, expected period in clocks}
  localparam int NV = 12;
  localparam logic [49:0] VEC [NV] = '{
    {2'b00, 16'd12,     32'd156},   // R3
    {2'b00, 16'd96,     32'd1248},  // R3
    {2'b00, 16'd1,      32'd13},    // R3
    {2'b01, 16'd8,      32'd13},    // R4
    {2'b01, 16'd16,     32'd26},    // R4
    {2'b01, 16'd24,     32'd39},    // R4
    {2'b10, 16'd12,     32'd12},    // R5
    {2'b11, 16'd300,    32'd300},   // R5
    {2'b10, 16'd0,      32'd1},     // R7
    {2'b11, 16'd1,      32'd1},     // R5
    {2'b10, 16'h0100,   32'd256},   // R2
    {2'b00, 16'h0003,   32'd39}     // R2
  };

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic write_byte(input logic sel, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_tick(output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!tick16 && n < 70000);
  endtask

  task automatic measure(output int per);
    int dummy;
    wait_tick(dummy);
    wait_tick(per);
  endtask

  initial begin
    #(8ns * 200000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual 0 expected 1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int per, lat, cnt;
    // R1: quiet in reset
    cnt = 0;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      if (tick16) cnt++;
    end
    check("R1 reset quiet", cnt, 0);
    rst_n = 1'b1;
    // R1/R7: reset divisor 0 acts as 1 in mode 00
    measure(per);
    check("R1 R7 reset divisor period", per, 13);

    for (int v = 0; v < NV; v++) begin
      @(negedge clk);
      mode = VEC[v][49:48];
      write_byte(1'b0, VEC[v][39:32]);
      write_byte(1'b1, VEC[v][47:40]);
      measure(per);
      check($sformatf("R2 R3 R4 R5 R7 vector %0d", v), per, int'(VEC[v][31:0]));
    end

    // R6: restart latency in bypass, D=20
    @(negedge clk); mode = 2'b10;
    write_byte(1'b1, 8'h00);
    write_byte(1'b0, 8'd20);
    check("R6 restart cycle quiet", int'(tick16), 0);
    wait_tick(lat);
    check("R6 bypass first tick", lat, 20);

    // R6: D=1 bypass, restart suppresses an otherwise constant strobe
    write_byte(1'b0, 8'd1);
    check("R6 suppress D1", int'(tick16), 0);
    @(negedge clk);
    check("R6 D1 next cycle", int'(tick16), 1);

    // R6: mode change restarts; D=3 in mode 00 -> 39
    @(negedge clk); mode = 2'b11;
    write_byte(1'b0, 8'd3);
    @(negedge clk); mode = 2'b00;
    @(negedge clk);
    check("R6 mode change quiet", int'(tick16), 0);
    wait_tick(lat);
    check("R6 div13 first tick", lat, 39);

    // R8: width one when period > 1
    @(negedge clk);
    check("R8 one wide", int'(tick16), 0);

    // R2: high byte write keeps low byte (low=5, high=1 -> 261)
    @(negedge clk); mode = 2'b10;
    write_byte(1'b0, 8'd5);
    measure(per);
    check("R2 low only", per, 5);
    write_byte(1'b1, 8'h01);
    measure(per);
    check("R2 low kept", per, 261);

    // R4: 64 strobes in 104 clocks with D=1 in mode 01
    write_byte(1'b1, 8'h00);
    write_byte(1'b0, 8'd1);
    @(negedge clk); mode = 2'b01;
    @(negedge clk);
    cnt = 0;
    for (int i = 0; i < 104; i++) begin
      @(negedge clk);
      if (tick16) cnt++;
    end
    check("R4 frac count", cnt, 64);

    // R9 via R3: no strobe between enables in mode 00, D=1 -> none in 12 clocks after a strobe
    @(negedge clk); mode = 2'b00;
    wait_tick(lat);
    cnt = 0;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      if (tick16) cnt++;
    end
    check("R9 only on enable", cnt, 0);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule